// File: doc/BRIEF.md
# Serial Snapshot Register Port

This block is a slave serial port that gives an external host access to eight 8-bit registers through one 64-bit shift register. When the host pulls chip select low, the port captures every register into the shift register in a single cycle. From then on, each serial clock moves one bit out to the host and one bit in from the host. When chip select returns high, the port may commit the two most recently received bytes. The last byte goes into the writable fields of the interrupt register and the byte before it goes into the control register. The commit takes place only if the top bit of the last byte is set.

The port also holds the interrupt logic. A 3-bit source code chooses one of six event inputs. A sticky interrupt flag is set by the chosen event and is cleared when the host reads the interrupt register. An active-low interrupt pin mirrors the flag. A resync request written by the host appears as a single-cycle pulse and never reads back as set. All serial pins are sampled in the system clock domain through synchronizers. Data is sampled on the rising serial clock and the output changes on the falling serial clock.

Top module: `spi_snap_regif`

## Requirements
- R1: On the falling edge of chip select, the whole register file is captured at once. Bytes go out in this order: interrupt register, quality, correction status, data high, data low, control, test 0, test 1. Each byte is sent least significant bit first. The interrupt register byte is laid out as follows: bit 0 is the interrupt flag, bits 3:1 are the source code, bit 4 is resync (always 0), bit 5 is the locked input, bit 6 is the block-seen input, and bit 7 is 0.
- R2: During a transfer, the port samples one input bit on each rising serial clock and presents the next output bit after the following falling serial clock.
- R3: A transfer may end after any number of bits. A 40-bit transfer returns the first five bytes of the snapshot.
- R4: When chip select rises and bit 7 of the last received byte is 1, the control register takes the byte received before it, and the source code takes bits 3:1 of the last byte.
- R5: When bit 7 of the last received byte is 0, neither the control register nor the source code changes.
- R6: A committed last byte with bit 4 set produces exactly one `resync_o` pulse, one clock long. The resync bit always reads back as 0.
- R7: The interrupt flag is set by the event selected by the source code, and `irq_n` is its inverse.
- R8: A transfer of at least 8 serial clocks clears the interrupt flag. A shorter transfer leaves it set.
- R9: A selected event that arrives after chip select falls is not cleared by that transfer.
- R10: Source code k (1 to 6) selects event input k-1. Code 1 is the "any new block" event on `evt_i[0]`. Codes 0 and 7 select no event.
- R11: Serial clock edges while chip select is high change neither the registers, the interrupt flag nor the next snapshot.
- R12: After reset, `irq_n` is 1, the control register holds `CTRL_RST` (default 0), the source code is 0 and `resync_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_sck | input | 1 | Serial clock from host, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| evt_i | input | 6 | Single-cycle event pulses: any block, block A, block B, block D, announcement, linked announcement |
| locked_i | input | 1 | Synchronized status shown in interrupt register bit 5 |
| blk_seen_i | input | 1 | Block-detected status shown in interrupt register bit 6 |
| qual_i | input | 8 | Quality register contents |
| corr_i | input | 8 | Correction-status register contents |
| data_hi_i | input | 8 | Upper byte of current data block |
| data_lo_i | input | 8 | Lower byte of current data block |
| test0_i | input | 8 | First test register contents |
| test1_i | input | 8 | Second test register contents |
| ctrl_o | output | 8 | Control register value |
| irq_n | output | 1 | Interrupt output, active low |
| resync_o | output | 1 | One-cycle resync request |

## Verification
The bench targets several corner cases. In the first, an event arrives after the snapshot but before the eighth clock. A design that clears on read without regard to timing would lose that interrupt and leave `irq_n` high. The bench also runs transfers shorter than eight clocks: a port that clears the flag on any access would release the pin too early. It toggles the serial clock while deselected: a port that does not gate on chip select would clear the flag or corrupt the next snapshot. Finally, it sends final bytes with bit 7 clear: a port that commits without checking the gate would overwrite the control register.

// File: rtl/spi_snap_pkg.sv
package spi_snap_pkg;

    localparam int REG_W    = 8;
    localparam int NUM_REGS = 8;
    localparam int SR_W     = REG_W * NUM_REGS;
    localparam int EVT_N    = 6;
    localparam int SRC_W    = 3;
    localparam int CNT_W    = $clog2(REG_W + 1);

    // Interrupt register layout, msb first
    typedef struct packed {
        logic             wr_gate;
        logic             blk_seen;
        logic             locked;
        logic             resync;
        logic [SRC_W-1:0] src;
        logic             irq;
    } int_reg_t;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE  = 3'd0,
        SRC_BLOCK = 3'd1,
        SRC_BLK_A = 3'd2,
        SRC_BLK_B = 3'd3,
        SRC_BLK_D = 3'd4,
        SRC_ANN   = 3'd5,
        SRC_ANN_L = 3'd6,
        SRC_OFF   = 3'd7
    } irq_src_e;

    // Code k in 1..EVT_N picks event k-1
    function automatic logic src_hit(input logic [SRC_W-1:0] src,
                                     input logic [EVT_N-1:0] evt);
        logic hit;
        hit = 1'b0;
        for (int k = 1; k <= EVT_N; k++) begin
            if (src == SRC_W'(k) && evt[k-1]) hit = 1'b1;
        end
        return hit;
    endfunction

    function automatic logic [SR_W-1:0] build_snap(
        input int_reg_t         ir,
        input logic [REG_W-1:0] qual,
        input logic [REG_W-1:0] corr,
        input logic [REG_W-1:0] dhi,
        input logic [REG_W-1:0] dlo,
        input logic [REG_W-1:0] ctrl,
        input logic [REG_W-1:0] t0,
        input logic [REG_W-1:0] t1);
        return {t1, t0, ctrl, dlo, dhi, corr, qual, ir};
    endfunction

endpackage

// File: rtl/spi_snap_sync.sv
module spi_snap_sync #(
    parameter int         STAGES  = 2,
    parameter int         W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_snap_shift.sv
module spi_snap_shift
    import spi_snap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n_s,
    input  logic             sck_s,
    input  logic             din_s,
    input  logic [SR_W-1:0]  snap,
    output logic             dout,
    output logic             snap_stb,
    output logic             rd_stb,
    output logic             wr_stb,
    output logic [REG_W-1:0] wr_last,
    output logic [REG_W-1:0] wr_prev
);
    logic [SR_W-1:0]  sr_q;
    logic [SR_W-1:0]  view;
    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic             pend_q;
    logic             in_bit_q;
    logic             cs_prev_q;
    logic             sck_prev_q;
    logic             cs_fall, cs_rise, sck_rise, sck_fall;

    always_comb begin
        cs_fall  = cs_prev_q & ~cs_n_s;
        cs_rise  = ~cs_prev_q & cs_n_s;
        sck_rise = active_q & sck_s & ~sck_prev_q;
        sck_fall = active_q & ~sck_s & sck_prev_q;
        // A bit sampled but not yet shifted still counts at release
        view     = pend_q ? {in_bit_q, sr_q[SR_W-1:1]} : sr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q       <= '0;
            cnt_q      <= '0;
            active_q   <= 1'b0;
            pend_q     <= 1'b0;
            in_bit_q   <= 1'b0;
            cs_prev_q  <= 1'b1;
            sck_prev_q <= 1'b0;
            rd_stb     <= 1'b0;
            wr_stb     <= 1'b0;
            wr_last    <= '0;
            wr_prev    <= '0;
        end else begin
            cs_prev_q  <= cs_n_s;
            sck_prev_q <= sck_s;
            rd_stb     <= 1'b0;
            wr_stb     <= 1'b0;
            if (cs_fall) begin
                sr_q     <= snap;
                active_q <= 1'b1;
                pend_q   <= 1'b0;
                cnt_q    <= '0;
            end else if (cs_rise) begin
                active_q <= 1'b0;
                pend_q   <= 1'b0;
                if (active_q) begin
                    wr_stb  <= view[SR_W-1];
                    wr_last <= view[SR_W-1 -: REG_W];
                    wr_prev <= view[SR_W-REG_W-1 -: REG_W];
                end
            end else if (sck_rise) begin
                in_bit_q <= din_s;
                pend_q   <= 1'b1;
                if (cnt_q != CNT_W'(REG_W)) cnt_q <= cnt_q + 1'b1;
                rd_stb   <= (cnt_q == CNT_W'(REG_W - 1));
            end else if (sck_fall && pend_q) begin
                sr_q   <= {in_bit_q, sr_q[SR_W-1:1]};
                pend_q <= 1'b0;
            end
        end
    end

    assign dout     = sr_q[0];
    assign snap_stb = cs_fall;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !cs_fall) |=> ($stable(sr_q) && !rd_stb)); // R11
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(REG_W)); // R8
    AST_RD_ONCE: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !rd_stb); // R8
    AST_WR_DESEL: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> !active_q); // R4

endmodule

// File: rtl/spi_snap_irq.sv
module spi_snap_irq
    import spi_snap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_N-1:0] evt,
    input  logic             snap_stb,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [SRC_W-1:0] src_wr,
    input  logic             rs_wr,
    output logic [SRC_W-1:0] src,
    output logic             irq,
    output logic             resync
);
    irq_src_e src_q;
    logic     irq_q;
    logic     rs_q;
    logic     snap_irq_q;
    logic     evt_seen_q;
    logic     sel_hit;

    always_comb sel_hit = src_hit(src_q, evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q      <= SRC_NONE;
            irq_q      <= 1'b0;
            rs_q       <= 1'b0;
            snap_irq_q <= 1'b0;
            evt_seen_q <= 1'b0;
        end else begin
            rs_q <= wr_stb & rs_wr;
            if (wr_stb) src_q <= irq_src_e'(src_wr);
            if (snap_stb) begin
                snap_irq_q <= irq_q;
                evt_seen_q <= sel_hit;
            end else if (sel_hit) begin
                evt_seen_q <= 1'b1;
            end
            // Clear only what the host has seen; a newer event wins
            if (sel_hit)
                irq_q <= 1'b1;
            else if (rd_stb && snap_irq_q && !evt_seen_q)
                irq_q <= 1'b0;
        end
    end

    assign src    = src_q;
    assign irq    = irq_q;
    assign resync = rs_q;

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
        sel_hit |=> irq_q); // R7
    AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_q) |-> $past(rd_stb)); // R8
    AST_NO_LOSS: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && evt_seen_q) |=> irq_q); // R9
    AST_RESYNC_ONE: assert property (@(posedge clk) disable iff (rst)
        rs_q |=> !rs_q); // R6

endmodule

// File: rtl/spi_snap_regif.sv
module spi_snap_regif
    import spi_snap_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [REG_W-1:0] CTRL_RST    = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_cs_n,
    input  logic             spi_sck,
    input  logic             spi_mosi,
    output logic             spi_miso,
    input  logic [EVT_N-1:0] evt_i,
    input  logic             locked_i,
    input  logic             blk_seen_i,
    input  logic [REG_W-1:0] qual_i,
    input  logic [REG_W-1:0] corr_i,
    input  logic [REG_W-1:0] data_hi_i,
    input  logic [REG_W-1:0] data_lo_i,
    input  logic [REG_W-1:0] test0_i,
    input  logic [REG_W-1:0] test1_i,
    output logic [REG_W-1:0] ctrl_o,
    output logic             irq_n,
    output logic             resync_o
);
    logic [2:0]       pins_s;
    logic [SR_W-1:0]  snap;
    logic             snap_stb, rd_stb, wr_stb;
    logic [REG_W-1:0] wr_last, wr_prev;
    logic [REG_W-1:0] ctrl_q;
    logic [SRC_W-1:0] src;
    logic             irq;
    int_reg_t         ir;

    spi_snap_sync #(
        .STAGES (SYNC_STAGES),
        .W      (3),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({spi_cs_n, spi_sck, spi_mosi}),
        .q  (pins_s)
    );

    always_comb begin
        ir          = '0;
        ir.blk_seen = blk_seen_i;
        ir.locked   = locked_i;
        ir.src      = src;
        ir.irq      = irq;
        snap = build_snap(ir, qual_i, corr_i, data_hi_i, data_lo_i,
                          ctrl_q, test0_i, test1_i);
    end

    spi_snap_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .cs_n_s  (pins_s[2]),
        .sck_s   (pins_s[1]),
        .din_s   (pins_s[0]),
        .snap    (snap),
        .dout    (spi_miso),
        .snap_stb(snap_stb),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb),
        .wr_last (wr_last),
        .wr_prev (wr_prev)
    );

    spi_snap_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt_i),
        .snap_stb(snap_stb),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb),
        .src_wr  (wr_last[3:1]),
        .rs_wr   (wr_last[4]),
        .src     (src),
        .irq     (irq),
        .resync  (resync_o)
    );

    always_ff @(posedge clk) begin
        if (rst)         ctrl_q <= CTRL_RST;
        else if (wr_stb) ctrl_q <= wr_prev;
    end

    assign ctrl_o = ctrl_q;
    assign irq_n  = ~irq;

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (ctrl_q == $past(wr_prev))); // R4
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(ctrl_q)); // R5
    AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(src)); // R5

endmodule

// File: tb/spi_snap_regif_tb_top.sv
module spi_snap_regif_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic       spi_miso;
    logic [5:0] evt_i = '0;
    logic       locked_i = 1'b0, blk_seen_i = 1'b0;
    logic [7:0] qual_i = '0, corr_i = '0, data_hi_i = '0, data_lo_i = '0;
    logic [7:0] test0_i = '0, test1_i = '0;
    logic [7:0] ctrl_o;
    logic       irq_n, resync_o;

    always #5 clk = ~clk;

    spi_snap_regif dut_i (
        .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .evt_i(evt_i),
        .locked_i(locked_i), .blk_seen_i(blk_seen_i), .qual_i(qual_i),
        .corr_i(corr_i), .data_hi_i(data_hi_i), .data_lo_i(data_lo_i),
        .test0_i(test0_i), .test1_i(test1_i), .ctrl_o(ctrl_o),
        .irq_n(irq_n), .resync_o(resync_o)
    );

    // [63:56] last byte sent, [55:48] byte before it, [47:0] status inputs
    localparam logic [63:0] VEC [4] = '{
        {8'h84, 8'h5A, 48'h1122_3344_5566},
        {8'h06, 8'hFF, 48'hA1B2_C3D4_E5F6},
        {8'h8E, 8'h3C, 48'h0F1E_2D3C_4B5A},
        {8'h00, 8'h81, 48'hFFEE_DDCC_BBAA}
    };

    int   checks = 0, errors = 0, rs_cnt = 0;
    bit   finished = 1'b0;
    logic [7:0] m_ctrl = 8'h00;
    logic [2:0] m_src = 3'd0;
    logic       m_irq = 1'b0;
    logic [63:0] rx, ex;

    always @(posedge clk) if (!rst && resync_o) rs_cnt++;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_lo();
        spi_cs_n = 1'b0;
        wait_clk(10);
    endtask

    task automatic cs_hi();
        wait_clk(6);
        spi_cs_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic sbit(input logic b, output logic r);
        spi_mosi = b;
        wait_clk(10);
        spi_sck = 1'b1;
        r = spi_miso;
        wait_clk(10);
        spi_sck = 1'b0;
    endtask

    task automatic xfer(input int n, input logic [63:0] tx, output logic [63:0] r);
        logic b;
        r = '0;
        cs_lo();
        for (int i = 0; i < n; i++) begin
            sbit(tx[i], b);
            r[i] = b;
        end
        cs_hi();
    endtask

    task automatic pulse(input int k);
        evt_i[k] = 1'b1;
        @(negedge clk);
        evt_i[k] = 1'b0;
        wait_clk(2);
    endtask

    function automatic logic [63:0] exp_snap();
        return {test1_i, test0_i, m_ctrl, data_lo_i, data_hi_i, corr_i, qual_i,
                1'b0, blk_seen_i, locked_i, 1'b0, m_src, m_irq};
    endfunction

    task automatic wr_int(input logic [7:0] ib);
        logic [63:0] r;
        xfer(16, {48'h0, ib, m_ctrl}, r);
        if (ib[7]) m_src = ib[3:1];
        m_irq = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL all-requirements watchdog actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic b;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        check("R12 irq_n after reset", 64'(irq_n), 64'd1);
        check("R12 ctrl after reset", 64'(ctrl_o), 64'h00);
        check("R12 resync after reset", 64'(resync_o), 64'd0);

        // Table walk: full snapshot read plus gated write
        for (int i = 0; i < 4; i++) begin
            {test1_i, test0_i, data_lo_i, data_hi_i, corr_i, qual_i} = VEC[i][47:0];
            locked_i   = i[0];
            blk_seen_i = i[1];
            wait_clk(2);
            ex = exp_snap();
            xfer(64, {VEC[i][63:48], 48'h0}, rx);
            check($sformatf("R1 R2 snapshot vec %0d", i), rx, ex);
            if (VEC[i][63]) begin
                m_ctrl = VEC[i][55:48];
                m_src  = VEC[i][59:57];
            end
            check($sformatf("R4 R5 ctrl after vec %0d", i), 64'(ctrl_o), 64'(m_ctrl));
        end
        locked_i = 1'b0;
        blk_seen_i = 1'b0;

        // R6: resync pulse, reads zero
        rs_cnt = 0;
        wr_int(8'h92);
        wait_clk(4);
        check("R6 one resync pulse", 64'(rs_cnt), 64'd1);
        xfer(8, 64'h0, rx);
        check("R6 R4 int byte readback", 64'(rx[7:0]), 64'({4'b0000, m_src, 1'b0}));

        // R7: selected event sets flag
        pulse(0);
        m_irq = 1'b1;
        check("R7 irq_n low on event", 64'(irq_n), 64'd0);

        // R8: short read keeps, 40-bit read clears
        xfer(5, 64'h0, rx);
        check("R8 flag seen in short read", 64'(rx[0]), 64'd1);
        check("R8 short read keeps flag", 64'(irq_n), 64'd0);
        ex = exp_snap();
        xfer(40, 64'h0, rx);
        m_irq = 1'b0;
        check("R3 40-bit read data", 64'(rx[39:0]), 64'(ex[39:0]));
        check("R8 full byte read clears", 64'(irq_n), 64'd1);

        // R9: event after snapshot survives the read
        pulse(0);
        cs_lo();
        for (int i = 0; i < 3; i++) sbit(1'b0, b);
        pulse(0);
        for (int i = 0; i < 5; i++) sbit(1'b0, b);
        cs_hi();
        check("R9 late event kept", 64'(irq_n), 64'd0);
        xfer(8, 64'h0, rx);
        check("R9 next read clears", 64'(irq_n), 64'd1);

        // R10: source select (code 3 -> evt_i[2])
        wr_int(8'h86);
        pulse(0);
        check("R10 unselected event ignored", 64'(irq_n), 64'd1);
        pulse(2);
        m_irq = 1'b1;
        check("R10 selected event sets", 64'(irq_n), 64'd0);

        // R11: clocks while deselected are ignored
        spi_mosi = 1'b1;
        for (int i = 0; i < 10; i++) begin
            spi_sck = 1'b1; wait_clk(6);
            spi_sck = 1'b0; wait_clk(6);
        end
        spi_mosi = 1'b0;
        check("R11 flag kept while deselected", 64'(irq_n), 64'd0);
        check("R11 ctrl kept while deselected", 64'(ctrl_o), 64'(m_ctrl));
        ex = exp_snap();
        xfer(64, 64'h0, rx);
        m_irq = 1'b0;
        check("R11 snapshot intact", rx, ex);
        check("R5 no write without gate", 64'(ctrl_o), 64'(m_ctrl));

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule